// File: doc/BRIEF.md
# Extended Address-Register Operation Decoder

This block takes the second 16-bit word of a prefixed instruction that acts on one of four address-register classes (base, scratchpad base, pointer scratchpad base, array scratchpad base) and turns it into a register class, an operation code, three register-number fields and a set of flags. The word is read as octal digits `1 C O xyz`. Bit 15 must be 1. The digit C in bits 14:12 picks the class and the operation group. The digit O in bits 11:9 picks the operation within that group. The low nine bits carry the destination, base and index register numbers.

The load-with-address operation writes a computed address into the destination register instead of reading memory at that address. When its base field is zero, it needs a 32-bit immediate that follows the instruction word. A small sequencer then collects two extra 16-bit words over a valid/ready port, high word first. The datapath forms the effective address as the immediate plus the selected index register's contents. A zero index selection adds nothing. The index register's contents come in on a plain input, and the decoder drives that register's number out.

One code range is listed both as single-register operations and as load/store-multiple operations. The decoder resolves that clash with a fixed priority and reports it on a flag. A `done` strobe marks the cycle in which all outputs and the effective address are valid.

Top module: `xbr_decoder`

## Requirements
- R1: After reset, `done` is 0, `inReady` is 1 and `extReady` is 0.
- R2: `regClass` is C[2:1], where C is bits 14:12. The encoding is 0 base, 1 scratchpad, 2 pointer scratchpad, 3 array scratchpad. The one exception is the multiple forms of R5.
- R3: For even C, O = 0..5 gives `regOp` 0..5: 0 swap, 1 compare, 2 load, 3 store, 4 add, 5 subtract. For even C, O = 6 or 7 is illegal.
- R4: For odd C, O = 2..5 gives `regOp` 6 load-address, 7 xor, 8 and, 9 or. For odd C, O = 0, 1, 6 and 7 are illegal, except for the case covered by R5.
- R5: C = 5 with O = 6 gives `regOp` 10 (load multiple), and C = 5 with O = 7 gives `regOp` 11 (store multiple). Both cases set `multi` and give `regClass` 3.
- R6: C = 5 with O = 2..5 decodes as the single-register operation of R4, with `multi` = 0 and `overlap` = 1. For every other code, `overlap` is 0.
- R7: A word with bit 15 = 0, or with an unlisted code, sets `illegal`. It also gives `regOp` 12 and clears `overlap`, `multi` and `needImm`.
- R8: `destSel` is bits 8:6, `baseSel` is bits 5:3 and `idxSel` is bits 2:0.
- R9: `needImm` is 1 exactly when the operation is a legal load-address with `baseSel` = 0. In that case the block raises `extReady` and takes two words, high word first. `done` does not rise until the second word has been taken.
- R10: In the immediate form, `effAddr` is the immediate plus `idxVal` when `idxSel` is nonzero, and the plain immediate when `idxSel` is zero. The sum wraps at 32 bits.
- R11: Without the immediate form, `extReady` stays 0. `effAddr` is `idxVal` when `idxSel` is nonzero, and 0 when it is zero.
- R12: `done` is 1 for exactly one cycle per accepted instruction word. The decoded outputs do not change while the block waits for immediate words.
- R13: `inReady` is 1 only while the block is idle, so no word is accepted while an earlier one is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction word offered |
| inReady | output | 1 | Block idle and able to take a word |
| inWord | input | 16 | Second instruction word |
| extValid | input | 1 | Immediate word offered |
| extReady | output | 1 | Block waiting for an immediate word |
| extWord | input | 16 | Immediate word, high half first |
| idxVal | input | 32 | Contents of the register named by idxSel |
| done | output | 1 | One-cycle result strobe |
| regClass | output | 2 | Address-register class |
| regOp | output | 4 | Operation code |
| destSel | output | 3 | Destination register number |
| baseSel | output | 3 | Base register number |
| idxSel | output | 3 | Index register number |
| needImm | output | 1 | Immediate form selected |
| illegal | output | 1 | Unlisted or malformed code |
| overlap | output | 1 | Code sits in the double-listed range |
| multi | output | 1 | Load/store-multiple form |
| effAddr | output | 32 | Computed effective address |

## Verification
The bench goes after the double-listed codes 152..155. A design that let the multiple form win would report `multi` with the wrong operation, and one that forgot the flag would leave `overlap` low. It also feeds the immediate words with a gap between them. A sequencer that finished after one word, or that swapped the halves, would strobe `done` early or give a wrong `effAddr`. The index addition is exercised with a zero selection, with a nonzero selection and with a sum that wraps, which catches an adder that ignores the selection or drops the index in the immediate form. Words with bit 15 clear, and the unlisted operation digits in both groups, must raise `illegal` without starting an immediate fetch.

// File: rtl/xbr_decoder_pkg.sv
package xbr_decoder_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 2 * WORD_W;
  localparam int SEL_W  = 3;

  typedef enum logic [1:0] {
    CLS_BASE = 2'd0, CLS_SCRATCH = 2'd1, CLS_POINTER = 2'd2, CLS_ARRAY = 2'd3
  } regClass_t;

  typedef enum logic [3:0] {
    OP_SWAP = 4'd0, OP_CMP = 4'd1, OP_LOAD = 4'd2, OP_STORE = 4'd3,
    OP_ADD = 4'd4, OP_SUB = 4'd5, OP_LDADDR = 4'd6, OP_XOR = 4'd7,
    OP_AND = 4'd8, OP_OR = 4'd9, OP_LDMULTI = 4'd10, OP_STMULTI = 4'd11,
    OP_NONE = 4'd12
  } regOp_t;

  typedef struct packed {
    regClass_t cls;
    regOp_t    op;
    logic      illegal;
    logic      overlap;
    logic      multi;
  } decode_t;

  typedef struct packed {
    logic loadWord;
    logic loadHi;
    logic loadLo;
    logic loadEa;
  } strobe_t;

  // Octal layout: bit15 = 1, C = [14:12], O = [11:9].
  function automatic decode_t decodeWord(input logic [WORD_W-1:0] w);
    decode_t d;
    logic [2:0] c;
    logic [2:0] o;
    c = w[14:12];
    o = w[11:9];
    d.cls     = regClass_t'(c[2:1]);
    d.op      = OP_NONE;
    d.illegal = 1'b1;
    d.overlap = 1'b0;
    d.multi   = 1'b0;
    if (w[15]) begin
      if (!c[0]) begin
        if (o <= 3'd5) begin
          d.op      = regOp_t'({1'b0, o});
          d.illegal = 1'b0;
        end
      end else if (o >= 3'd2 && o <= 3'd5) begin
        // Single-register form has priority over the multiple form.
        d.op      = regOp_t'(4'd4 + {1'b0, o});
        d.illegal = 1'b0;
        d.overlap = (c == 3'd5);
      end else if (c == 3'd5 && o >= 3'd6) begin
        d.op      = o[0] ? OP_STMULTI : OP_LDMULTI;
        d.cls     = CLS_ARRAY;
        d.multi   = 1'b1;
        d.illegal = 1'b0;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/xbr_decoder_ctrl.sv
module xbr_decoder_ctrl
  import xbr_decoder_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    extValid,
  input  logic    needImm,
  output logic    inReady,
  output logic    extReady,
  output logic    done,
  output strobe_t strobe
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_HIGH, ST_LOW, ST_CALC, ST_DONE
  } state_t;

  state_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (inValid) stateNext = ST_EVAL;
      ST_EVAL: stateNext = needImm ? ST_HIGH : ST_DONE;
      ST_HIGH: if (extValid) stateNext = ST_LOW;
      ST_LOW:  if (extValid) stateNext = ST_CALC;
      ST_CALC: stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign inReady  = (state == ST_IDLE);
  assign extReady = (state == ST_HIGH) || (state == ST_LOW);
  assign done     = (state == ST_DONE);

  always_comb begin
    strobe.loadWord = (state == ST_IDLE) && inValid;
    strobe.loadHi   = (state == ST_HIGH) && extValid;
    strobe.loadLo   = (state == ST_LOW) && extValid;
    strobe.loadEa   = ((state == ST_EVAL) && !needImm) || (state == ST_CALC);
  end
endmodule

// File: rtl/xbr_decoder_dp.sv
module xbr_decoder_dp
  import xbr_decoder_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] inWord,
  input  logic [WORD_W-1:0] extWord,
  input  logic [ADDR_W-1:0] idxVal,
  output logic [1:0]        regClass,
  output logic [3:0]        regOp,
  output logic [SEL_W-1:0]  destSel,
  output logic [SEL_W-1:0]  baseSel,
  output logic [SEL_W-1:0]  idxSel,
  output logic              needImm,
  output logic              illegal,
  output logic              overlap,
  output logic              multi,
  output logic [ADDR_W-1:0] effAddr
);
  logic [WORD_W-1:0] wordQ;
  logic [ADDR_W-1:0] immQ;
  logic [ADDR_W-1:0] eaQ;
  logic [ADDR_W-1:0] idxPart;
  logic [ADDR_W-1:0] immPart;
  decode_t           dec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0;
      immQ  <= '0;
      eaQ   <= '0;
    end else begin
      if (strobe.loadWord) wordQ <= inWord;
      if (strobe.loadHi)   immQ[ADDR_W-1:WORD_W] <= extWord;
      if (strobe.loadLo)   immQ[WORD_W-1:0] <= extWord;
      if (strobe.loadEa)   eaQ <= immPart + idxPart;
    end
  end

  assign dec     = decodeWord(wordQ);
  assign destSel = wordQ[8:6];
  assign baseSel = wordQ[5:3];
  assign idxSel  = wordQ[2:0];
  assign needImm = !dec.illegal && (dec.op == OP_LDADDR) && (baseSel == '0);
  assign idxPart = (idxSel != '0) ? idxVal : '0;
  assign immPart = needImm ? immQ : '0;

  assign regClass = dec.cls;
  assign regOp    = dec.op;
  assign illegal  = dec.illegal;
  assign overlap  = dec.overlap;
  assign multi    = dec.multi;
  assign effAddr  = eaQ;
endmodule

// File: rtl/xbr_decoder.sv
module xbr_decoder
  import xbr_decoder_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inWord,
  input  logic              extValid,
  output logic              extReady,
  input  logic [WORD_W-1:0] extWord,
  input  logic [ADDR_W-1:0] idxVal,
  output logic              done,
  output logic [1:0]        regClass,
  output logic [3:0]        regOp,
  output logic [SEL_W-1:0]  destSel,
  output logic [SEL_W-1:0]  baseSel,
  output logic [SEL_W-1:0]  idxSel,
  output logic              needImm,
  output logic              illegal,
  output logic              overlap,
  output logic              multi,
  output logic [ADDR_W-1:0] effAddr
);
  strobe_t strobe;

  xbr_decoder_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .extValid(extValid),
    .needImm(needImm), .inReady(inReady), .extReady(extReady),
    .done(done), .strobe(strobe)
  );

  xbr_decoder_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inWord(inWord),
    .extWord(extWord), .idxVal(idxVal), .regClass(regClass),
    .regOp(regOp), .destSel(destSel), .baseSel(baseSel), .idxSel(idxSel),
    .needImm(needImm), .illegal(illegal), .overlap(overlap),
    .multi(multi), .effAddr(effAddr)
  );
endmodule

// File: rtl/xbr_decoder_chk.sv
module xbr_decoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic       inReady,
  input logic       extReady,
  input logic       done,
  input logic [1:0] regClass,
  input logic [3:0] regOp,
  input logic [2:0] destSel,
  input logic       needImm,
  input logic       illegal,
  input logic       overlap,
  input logic       multi
);
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r12_hold_while_fetching: assert property (@(posedge clk) disable iff (!rstN)
    extReady |=> ($stable(regOp) && $stable(regClass) && $stable(destSel)));

  a_r9_fetch_only_immediate: assert property (@(posedge clk) disable iff (!rstN)
    extReady |-> needImm);

  a_r13_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (done || extReady) |-> !inReady);

  a_r6_overlap_single: assert property (@(posedge clk) disable iff (!rstN)
    overlap |-> (!multi && !illegal && regOp >= 4'd6 && regOp <= 4'd9));

  a_r5_multi_array: assert property (@(posedge clk) disable iff (!rstN)
    multi |-> (regClass == 2'd3 && (regOp == 4'd10 || regOp == 4'd11)));

  a_r7_illegal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (regOp == 4'd12 && !needImm && !overlap && !multi));
endmodule

bind xbr_decoder xbr_decoder_chk u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .extReady(extReady),
  .done(done), .regClass(regClass), .regOp(regOp), .destSel(destSel),
  .needImm(needImm), .illegal(illegal), .overlap(overlap), .multi(multi)
);

// File: tb/xbr_decoder_bench.sv
`timescale 1ns/1ps
module xbr_decoder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inWord = '0;
  logic        extValid = 1'b0;
  logic        extReady;
  logic [15:0] extWord = '0;
  logic [31:0] idxVal = '0;
  logic        done;
  logic [1:0]  regClass;
  logic [3:0]  regOp;
  logic [2:0]  destSel, baseSel, idxSel;
  logic        needImm, illegal, overlap, multi;
  logic [31:0] effAddr;

  typedef struct {
    logic [15:0] word;
    logic [1:0]  cls;
    logic [3:0]  op;
    logic        ill;
    logic        ovl;
    logic        mul;
    logic        imm;
    logic [31:0] ea;
  } expect_t;

  expect_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  logic prevDone = 1'b0;

  always #4 clk = ~clk;

  xbr_decoder u_xbr_decoder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inWord(inWord), .extValid(extValid), .extReady(extReady),
    .extWord(extWord), .idxVal(idxVal), .done(done), .regClass(regClass),
    .regOp(regOp), .destSel(destSel), .baseSel(baseSel), .idxSel(idxSel),
    .needImm(needImm), .illegal(illegal), .overlap(overlap), .multi(multi),
    .effAddr(effAddr)
  );

  task automatic check(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per done strobe.
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (prevDone) check(!done, "R12 done longer than one cycle", done, 0);
      if (done) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R12 unexpected done", 1, 0);
        end else begin
          expect_t e;
          e = expQ.pop_front();
          check(regClass == e.cls, "R2 class", regClass, e.cls);
          check(regOp == e.op, "R3/R4 op", regOp, e.op);
          check({illegal, overlap, multi} == {e.ill, e.ovl, e.mul},
                "R5/R6/R7 flags", {illegal, overlap, multi}, {e.ill, e.ovl, e.mul});
          check({destSel, baseSel, idxSel} == e.word[8:0], "R8 fields",
                {destSel, baseSel, idxSel}, e.word[8:0]);
          check(needImm == e.imm, "R9 needImm", needImm, e.imm);
          check(effAddr == e.ea, "R10/R11 effAddr", effAddr, e.ea);
        end
      end
    end
    prevDone = done;
  end

  initial begin
    #800000;
    check(1'b0, "watchdog expired", cycles, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  task automatic send(input logic [15:0] w, input logic [1:0] cls,
                      input logic [3:0] op, input logic ill, input logic ovl,
                      input logic mul, input logic imm, input logic [31:0] immVal,
                      input logic [31:0] idx, input logic [31:0] ea);
    expect_t e;
    e.word = w; e.cls = cls; e.op = op; e.ill = ill; e.ovl = ovl;
    e.mul = mul; e.imm = imm; e.ea = ea;
    expQ.push_back(e);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inWord = w; idxVal = idx;
    @(negedge clk);
    inValid = 1'b0;
    check(!inReady, "R13 busy after accept", inReady, 0);
    if (imm) begin
      while (!extReady) @(negedge clk);
      extValid = 1'b1; extWord = immVal[31:16];
      @(negedge clk);
      extValid = 1'b0;
      for (int k = 0; k < 3; k++) begin
        check(!done, "R9 done before low word", done, 0);
        @(negedge clk);
      end
      while (!extReady) @(negedge clk);
      extValid = 1'b1; extWord = immVal[15:0];
      @(negedge clk);
      extValid = 1'b0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        check(!extReady, "R11 no immediate fetch", extReady, 0);
        @(negedge clk);
      end
    end
    while (expQ.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && inReady && !extReady, "R1 reset state",
          {done, inReady, extReady}, 3'b010);
    rstN = 1'b1;
    // word, cls, op, ill, ovl, mul, imm, immVal, idxVal, ea
    send(16'o100123, 2'd0, 4'd0,  0, 0, 0, 0, 0, 32'h10, 32'h10);          // R3 swap, R11
    send(16'o101000, 2'd0, 4'd1,  0, 0, 0, 0, 0, 32'h99, 32'h0);           // R11 zero index
    send(16'o122345, 2'd1, 4'd2,  0, 0, 0, 0, 0, 32'h7, 32'h7);            // R2 scratchpad
    send(16'o145012, 2'd2, 4'd5,  0, 0, 0, 0, 0, 32'h5, 32'h5);            // R2 pointer
    send(16'o163777, 2'd3, 4'd3,  0, 0, 0, 0, 0, 32'hABC, 32'hABC);        // R2 array
    send(16'o112520, 2'd0, 4'd6,  0, 0, 0, 0, 0, 32'h1, 32'h0);            // R4 ldaddr base!=0
    send(16'o112300, 2'd0, 4'd6,  0, 0, 0, 1, 32'h12345678, 32'h4, 32'h12345678); // R9 R10
    send(16'o132204, 2'd1, 4'd6,  0, 0, 0, 1, 32'h0000FFF0, 32'h20, 32'h00010010); // R10
    send(16'o152607, 2'd2, 4'd6,  0, 1, 0, 1, 32'hFFFFFFFF, 32'h2, 32'h1);  // R6 R10 wrap
    send(16'o153111, 2'd2, 4'd7,  0, 1, 0, 0, 0, 32'h3, 32'h3);            // R6 xor
    send(16'o155000, 2'd2, 4'd9,  0, 1, 0, 0, 0, 32'h0, 32'h0);            // R6 or
    send(16'o156444, 2'd3, 4'd10, 0, 0, 1, 0, 0, 32'h8, 32'h8);            // R5 load multi
    send(16'o157001, 2'd3, 4'd11, 0, 0, 1, 0, 0, 32'h9, 32'h9);            // R5 store multi
    send(16'o173000, 2'd3, 4'd7,  0, 0, 0, 0, 0, 32'h0, 32'h0);            // R4 xor array
    send(16'o174000, 2'd3, 4'd8,  0, 0, 0, 0, 0, 32'h0, 32'h0);            // R4 and
    send(16'o106000, 2'd0, 4'd12, 1, 0, 0, 0, 0, 32'h0, 32'h0);            // R3 illegal op 6
    send(16'o110000, 2'd0, 4'd12, 1, 0, 0, 0, 0, 32'h0, 32'h0);            // R4 illegal op 0
    send(16'o137000, 2'd1, 4'd12, 1, 0, 0, 0, 0, 32'h0, 32'h0);            // R4 illegal op 7
    send(16'o052000, 2'd2, 4'd12, 1, 0, 0, 0, 0, 32'h0, 32'h0);            // R7 bit15 clear
    send(16'o132000, 2'd1, 4'd6,  0, 0, 0, 1, 32'hCAFE0000, 32'h0, 32'hCAFE0000); // R10 no idx
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule